// File: doc/BRIEF.md
# TDMA Slot Scheduler with Global Time

This block keeps a node's local copy of a network-wide time base. It uses that time base to step through a fixed time-division schedule. Internal clock cycles (microticks) are divided down into macroticks, the unit of global time. Macroticks are grouped into slots, slots into rounds, and a fixed number of rounds into a cluster cycle. The cluster cycle repeats without end. The node may drive the shared medium only inside the slots that the schedule assigns to it. The block raises a transmit-enable window for exactly those slots.

The schedule is a small table that is written before operation starts. Each entry gives a slot length in macroticks and the identifier of the node that owns the slot. The table is indexed by round and slot together, so ownership can change from one round to the next. When the configuration-done input rises, the block latches the microtick divider and the local node identifier. It then starts counting and ignores any further table writes. Its outputs are a microtick indication, a macrotick pulse, a wrap-to-zero pulse of the global time, the global time value, the current slot and round indices, and the transmit enable.

Top module: `tdma_sched_top`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, every output is 0.
- R2: Until `cfg_done` is seen high, the schedule stays idle. `utick_o`, `mtick_o`, `ovf_o` and `tx_en_o` stay 0, and `gtime_o`, `slot_o` and `round_o` stay 0.
- R3: On the clock edge that starts the schedule, `utick_o` is 0. After that it inverts on every clock edge.
- R4: `cfg_div` is latched at start, and a value of 0 is treated as 1. `mtick_o` is a one-cycle pulse after clock edge number k·div, counting the start edge as number 0, for every k ≥ 1.
- R5: `gtime_o` is 0 at start. It rises by one on each macrotick edge and wraps from 2^GT_W−1 to 0.
- R6: `ovf_o` pulses on exactly those macrotick edges that bring `gtime_o` to 0.
- R7: The entry at index {round, slot} lasts its length in macroticks, and a length of 0 counts as 1. The slot index advances on the same edge as the macrotick that ends the slot, with no idle cycle between slots.
- R8: After the last slot (all ones), the slot index wraps to 0 and the round index increments. After the last round, the schedule restarts at slot 0 of round 0. Entry address = round·2^SLOT_W + slot.
- R9: `tx_en_o` is 1 for the whole of a slot exactly when that entry's owner equals the node identifier latched at start. It changes on the same edge as `slot_o`.
- R10: A table write is ignored while `cfg_done` is high or the schedule is running. Later slots keep the lengths and owners that were loaded before start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one microtick |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | Configuration complete; starts the schedule |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | SLOT_W+ROUND_W | Table entry address {round, slot} |
| cfg_len | input | LEN_W | Slot length in macroticks |
| cfg_owner | input | NODE_W | Owning node identifier |
| cfg_div | input | DIV_W | Microticks per macrotick, latched at start |
| node_id | input | NODE_W | Local node identifier, latched at start |
| utick_o | output | 1 | Microtick indication, toggles each clock while running |
| mtick_o | output | 1 | Macrotick pulse |
| ovf_o | output | 1 | Global time wrap-to-zero pulse |
| tx_en_o | output | 1 | Transmit enable for the local node's slots |
| slot_o | output | SLOT_W | Current slot index |
| round_o | output | ROUND_W | Current round index |
| gtime_o | output | GT_W | Global time in macroticks |

## Verification
The assertions assume the following about the inputs:
- Reset is applied before the first start.
- Once the schedule is running, `cfg_done` stays high until the next reset.

The properties about slot holding and round stepping depend on this: the indices only ever start from their reset value of zero. The stimulus raises `cfg_done` once per reset, only after the whole table has been written, and keeps it high for the rest of the run. Each scenario begins with a fresh reset. The write that is made while running, and the change of `node_id` that goes with it, only probe that both are ignored.

// File: rtl/tdma_pkg.sv
`timescale 1ns/1ps
package tdma_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/tdma_tick_gen.sv
`timescale 1ns/1ps
// Microtick to macrotick divider and global time counter.
module tdma_tick_gen #(
  parameter int DIV_W = 8,
  parameter int GT_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             mt_fire,
  output logic             utick_o,
  output logic             mtick_o,
  output logic             ovf_o,
  output logic [GT_W-1:0]  gtime_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] ucnt_q;

  // combinational fire so the sequencer advances on the same edge
  assign mt_fire = run && (ucnt_q == div_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= DIV_W'(1);
      ucnt_q  <= '0;
      utick_o <= 1'b0;
      mtick_o <= 1'b0;
      ovf_o   <= 1'b0;
      gtime_o <= '0;
    end else if (start) begin
      div_q   <= (div_in == '0) ? DIV_W'(1) : div_in;
      ucnt_q  <= '0;
      utick_o <= 1'b0;
      mtick_o <= 1'b0;
      ovf_o   <= 1'b0;
      gtime_o <= '0;
    end else if (run) begin
      utick_o <= ~utick_o;
      ucnt_q  <= mt_fire ? '0 : ucnt_q + 1'b1;
      mtick_o <= mt_fire;
      ovf_o   <= mt_fire && (gtime_o == '1);
      if (mt_fire) gtime_o <= gtime_o + 1'b1;
    end
  end
endmodule

// File: rtl/tdma_sched_table.sv
`timescale 1ns/1ps
// Schedule table: one write port, two asynchronous read ports.
module tdma_sched_table #(
  parameter int ADDR_W = 3,
  parameter int LEN_W  = 8,
  parameter int NODE_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LEN_W-1:0]  wlen,
  input  logic [NODE_W-1:0] wowner,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [LEN_W-1:0]  rlen_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [NODE_W-1:0] rowner_b
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [LEN_W-1:0]  len_mem   [DEPTH];
  logic [NODE_W-1:0] owner_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      len_mem[waddr]   <= wlen;
      owner_mem[waddr] <= wowner;
    end
  end

  assign rlen_a   = len_mem[raddr_a];
  assign rowner_b = owner_mem[raddr_b];
endmodule

// File: rtl/tdma_slot_seq.sv
`timescale 1ns/1ps
// Slot / round sequencer: counts macroticks inside a slot and steps indices.
module tdma_slot_seq #(
  parameter int SLOT_W  = 2,
  parameter int ROUND_W = 1,
  parameter int LEN_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       mt_fire,
  input  logic [LEN_W-1:0]           cur_len,
  output logic [SLOT_W+ROUND_W-1:0]  cur_idx,
  output logic [SLOT_W+ROUND_W-1:0]  nxt_idx,
  output logic [SLOT_W-1:0]          slot_o,
  output logic [ROUND_W-1:0]         round_o
);
  logic [LEN_W-1:0]   mcnt_q;
  logic [LEN_W-1:0]   len_eff;
  logic               slot_end;
  logic [SLOT_W-1:0]  nxt_slot;
  logic [ROUND_W-1:0] nxt_round;

  assign len_eff  = (cur_len == '0) ? LEN_W'(1) : cur_len;
  assign slot_end = mt_fire && (mcnt_q == len_eff - 1'b1);

  always_comb begin
    nxt_slot  = slot_o;
    nxt_round = round_o;
    if (start) begin
      nxt_slot  = '0;
      nxt_round = '0;
    end else if (slot_end) begin
      nxt_slot = slot_o + 1'b1;
      if (slot_o == '1) nxt_round = round_o + 1'b1;
    end
  end

  assign cur_idx = {round_o, slot_o};
  assign nxt_idx = {nxt_round, nxt_slot};

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_o  <= '0;
      round_o <= '0;
      mcnt_q  <= '0;
    end else begin
      slot_o  <= nxt_slot;
      round_o <= nxt_round;
      if (start || slot_end) mcnt_q <= '0;
      else if (mt_fire)      mcnt_q <= mcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tdma_sched_top.sv
`timescale 1ns/1ps
module tdma_sched_top #(
  parameter int SLOT_W  = 2,
  parameter int ROUND_W = 1,
  parameter int LEN_W   = 8,
  parameter int NODE_W  = 4,
  parameter int DIV_W   = 8,
  parameter int GT_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_done,
  input  logic                      cfg_we,
  input  logic [SLOT_W+ROUND_W-1:0] cfg_addr,
  input  logic [LEN_W-1:0]          cfg_len,
  input  logic [NODE_W-1:0]         cfg_owner,
  input  logic [DIV_W-1:0]          cfg_div,
  input  logic [NODE_W-1:0]         node_id,
  output logic                      utick_o,
  output logic                      mtick_o,
  output logic                      ovf_o,
  output logic                      tx_en_o,
  output logic [SLOT_W-1:0]         slot_o,
  output logic [ROUND_W-1:0]        round_o,
  output logic [GT_W-1:0]           gtime_o
);
  import tdma_pkg::*;

  localparam int ADDR_W = SLOT_W + ROUND_W;

  run_state_e        st_q;
  logic              run_q;
  logic              start;
  logic              tab_we;
  logic              mt_fire;
  logic [NODE_W-1:0] local_id_q;
  logic [ADDR_W-1:0] cur_idx;
  logic [ADDR_W-1:0] nxt_idx;
  logic [LEN_W-1:0]  cur_len;
  logic [NODE_W-1:0] nxt_owner;

  assign run_q  = (st_q == ST_RUN);
  assign start  = (st_q == ST_IDLE) && cfg_done;
  assign tab_we = cfg_we && !run_q && !cfg_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      local_id_q <= '0;
    end else if (start) begin
      st_q       <= ST_RUN;
      local_id_q <= node_id;
    end
  end

  tdma_tick_gen #(.DIV_W(DIV_W), .GT_W(GT_W)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .run     (run_q),
    .div_in  (cfg_div),
    .mt_fire (mt_fire),
    .utick_o (utick_o),
    .mtick_o (mtick_o),
    .ovf_o   (ovf_o),
    .gtime_o (gtime_o)
  );

  tdma_sched_table #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NODE_W(NODE_W)) u_tab (
    .clk      (clk),
    .we       (tab_we),
    .waddr    (cfg_addr),
    .wlen     (cfg_len),
    .wowner   (cfg_owner),
    .raddr_a  (cur_idx),
    .rlen_a   (cur_len),
    .raddr_b  (nxt_idx),
    .rowner_b (nxt_owner)
  );

  tdma_slot_seq #(.SLOT_W(SLOT_W), .ROUND_W(ROUND_W), .LEN_W(LEN_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mt_fire (mt_fire),
    .cur_len (cur_len),
    .cur_idx (cur_idx),
    .nxt_idx (nxt_idx),
    .slot_o  (slot_o),
    .round_o (round_o)
  );

  // transmit window follows the owner of the entry the indices move to
  always_ff @(posedge clk) begin
    if (rst) tx_en_o <= 1'b0;
    else     tx_en_o <= (start || run_q) &&
                        (nxt_owner == (start ? node_id : local_id_q));
  end
endmodule

// File: rtl/tdma_sched_chk.sv
`timescale 1ns/1ps
module tdma_sched_chk #(
  parameter int SLOT_W  = 2,
  parameter int ROUND_W = 1,
  parameter int GT_W    = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               run,
  input logic               utick,
  input logic               mtick,
  input logic               ovf,
  input logic               tx_en,
  input logic [SLOT_W-1:0]  slot,
  input logic [ROUND_W-1:0] round,
  input logic [GT_W-1:0]    gtime
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> (!tx_en && !mtick && !utick && !ovf));

  // R3
  utick_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> (utick != $past(utick)));

  // R5
  gtime_step_chk: assert property (@(posedge clk) disable iff (rst)
    mtick |-> (gtime == GT_W'($past(gtime) + 1'b1)));

  // R5
  gtime_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mtick |-> $stable(gtime));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (mtick && gtime == '0));

  // R7
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mtick |-> ($stable(slot) && $stable(round)));

  // R8
  round_step_chk: assert property (@(posedge clk) disable iff (rst)
    (round != $past(round)) |-> (slot == '0));
endmodule

bind tdma_sched_top tdma_sched_chk #(
  .SLOT_W(SLOT_W), .ROUND_W(ROUND_W), .GT_W(GT_W)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .run   (run_q),
  .utick (utick_o),
  .mtick (mtick_o),
  .ovf   (ovf_o),
  .tx_en (tx_en_o),
  .slot  (slot_o),
  .round (round_o),
  .gtime (gtime_o)
);

// File: tb/tdma_sched_top_tb.sv
`timescale 1ns/1ps
module tdma_sched_top_tb;
  localparam int GTW = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_done = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_len = '0;
  logic [3:0] cfg_owner = '0;
  logic [7:0] cfg_div = '0;
  logic [3:0] node_id = '0;
  logic       utick, mtick, ovf, tx_en;
  logic [1:0] slot;
  logic [0:0] round;
  logic [GTW-1:0] gtime;

  int checks = 0;
  int errors = 0;
  int lens [8];
  int owns [8];
  int div_eff;
  int my_id;

  always #2.5 clk = ~clk;

  tdma_sched_top #(.GT_W(GTW)) u_dut (
    .clk(clk), .rst(rst), .cfg_done(cfg_done), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_len(cfg_len), .cfg_owner(cfg_owner),
    .cfg_div(cfg_div), .node_id(node_id), .utick_o(utick), .mtick_o(mtick),
    .ovf_o(ovf), .tx_en_o(tx_en), .slot_o(slot), .round_o(round), .gtime_o(gtime)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // entry index that is active at macrotick count mt
  function automatic int exp_idx(input int mt);
    int total = 0;
    int p;
    for (int i = 0; i < 8; i++) total += (lens[i] == 0) ? 1 : lens[i];
    p = mt % total;
    for (int i = 0; i < 8; i++) begin
      int e = (lens[i] == 0) ? 1 : lens[i];
      if (p < e) return i;
      p -= e;
    end
    return 0;
  endfunction

  task automatic check_quiet(input string req);
    check(req, "utick", utick, 0);
    check(req, "mtick", mtick, 0);
    check(req, "ovf", ovf, 0);
    check(req, "tx_en", tx_en, 0);
    check(req, "slot", slot, 0);
    check(req, "round", round, 0);
    check(req, "gtime", gtime, 0);
  endtask

  // R1: reset state
  task automatic t_reset();
    rst = 1'b1; cfg_done = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    check_quiet("R1");
    rst = 1'b0;
    @(negedge clk);
    check_quiet("R1");
  endtask

  // R2: table load with cfg_done low, schedule must stay idle
  task automatic t_load();
    for (int i = 0; i < 8; i++) begin
      cfg_we = 1'b1; cfg_addr = 3'(i);
      cfg_len = 8'(lens[i]); cfg_owner = 4'(owns[i]);
      @(negedge clk);
      check_quiet("R2");
    end
    cfg_we = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check_quiet("R2");
    end
  endtask

  task automatic compare(input int n);
    int mt  = n / div_eff;
    int idx = exp_idx(mt);
    int mt_exp = (n > 0 && (n % div_eff) == 0) ? 1 : 0;
    check("R3", "utick", utick, n % 2);
    check("R4", "mtick", mtick, mt_exp);
    check("R5", "gtime", gtime, mt % 256);
    check("R6", "ovf", ovf, (mt_exp == 1 && (mt % 256) == 0) ? 1 : 0);
    check("R7", "slot", slot, idx % 4);
    check("R8", "round", round, idx / 4);
    check("R9", "tx_en", tx_en, (owns[idx] == my_id) ? 1 : 0);
  endtask

  // start and compare every cycle; at poke_at a table write and an id change
  // are issued, which must have no effect (R10, R9 latching)
  task automatic t_run(input int div, input int id, input int ncyc, input int poke_at);
    cfg_div = 8'(div); node_id = 4'(id);
    div_eff = (div == 0) ? 1 : div;
    my_id = id;
    cfg_done = 1'b1;
    @(negedge clk);
    for (int n = 0; n < ncyc; n++) begin
      compare(n);
      if (n == poke_at) begin
        cfg_we = 1'b1; cfg_addr = 3'd1; cfg_len = 8'd9;
        cfg_owner = 4'(id); node_id = 4'(id + 1);
      end
      if (n == poke_at + 1) cfg_we = 1'b0;
      @(negedge clk);
    end
    cfg_we = 1'b0;
  endtask

  // scenario A: divide by 3, mixed lengths, write while running ignored
  task automatic t_scen_a();
    lens = '{2, 1, 3, 1, 1, 2, 1, 2};
    owns = '{1, 5, 3, 2, 5, 2, 1, 7};
    t_reset();
    t_load();
    t_run(3, 2, 300, 10);
  endtask

  // scenario B: divider 0 taken as 1, zero-length slot, global time wrap
  task automatic t_scen_b();
    lens = '{1, 1, 0, 2, 1, 1, 1, 3};
    owns = '{4, 4, 1, 4, 0, 4, 4, 2};
    t_reset();
    t_load();
    t_run(0, 4, 600, -5);
  endtask

  // scenario C: single-macrotick slots, alternating ownership
  task automatic t_scen_c();
    lens = '{1, 1, 1, 1, 1, 1, 1, 1};
    owns = '{3, 0, 3, 0, 0, 3, 0, 3};
    t_reset();
    t_load();
    t_run(2, 3, 120, 7);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_scen_a();
    t_scen_b();
    t_scen_c();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule